// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings one rank of asynchronous DRAM out of power-up and then keeps it refreshed. Out of reset it holds the row and column strobes inactive (high) for a programmable pause. It then runs a fixed number of column-before-row initialization cycles and raises `ready`. Until `ready` is high the sequencer owns the strobes outright and the host must not issue accesses.

Once ready, a distributed interval timer marks one refresh as owed every `INTERVAL_CYC` clocks. A saturating backlog counter records how many are owed. While anything is owed, or a refresh cycle is in progress, the block raises `rfsh_req` toward the access controller. The controller answers with `rfsh_grant` and must keep it high until `rfsh_req` falls. On each refresh decision the block samples the grant: every owed refresh is then issued back to back, and the strobes are released when the backlog is empty. A grant that arrives while nothing is owed does nothing.

Each refresh cycle drops CAS one or more clocks before RAS and holds CAS low for the whole RAS-low time. Both strobes rise together and then stay high for the precharge time. The write strobe is held high throughout. All strobe times are counted in clocks and set by parameters. The defaults assume a 100 MHz clock: a 200 µs pause, a 16 µs interval, 70 ns RAS low, 40 ns precharge and a 120 ns cycle.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, and for `PAUSE_CYC` clocks after the first rising edge with `rst_n` high, `ras_n` and `cas_n` are 1, `strobe_own` is 1, and `ready` and `rfsh_req` are 0.
- R2: Right after the pause, exactly `INIT_CYCLES` refresh cycles run back to back whatever `rfsh_grant` does. `ready` first reads 1 after `PAUSE_CYC + INIT_CYCLES*(CAS_LEAD_CYC+RAS_LOW_CYC+PRECH_CYC)` rising edges.
- R3: Once `ready` is 1 it stays 1 until reset.
- R4: Each refresh cycle holds `cas_n`=0 with `ras_n`=1 for `CAS_LEAD_CYC` clocks. It then holds both at 0 for `RAS_LOW_CYC` clocks, and after that both at 1 for at least `PRECH_CYC` clocks before CAS falls again. `we_n` is 1 in every clock.
- R5: After `ready`, one refresh becomes owed at the end of every `INTERVAL_CYC`-th clock in which `ready` is high.
- R6: `rfsh_req` = `ready` AND (refreshes owed > 0 OR a refresh cycle in progress).
- R7: After `ready`, a refresh cycle starts (CAS falls) only in the clock after a rising edge at which `rfsh_grant` was 1 and a refresh was owed.
- R8: The owed count saturates at `BACKLOG_MAX`. After the grant has been withheld for more than `BACKLOG_MAX` intervals, exactly `BACKLOG_MAX` cycles are issued back to back, provided no new interval ends during the burst.
- R9: `rfsh_grant` held high while nothing is owed has no effect: the strobes stay high and `strobe_own` stays 0.
- R10: `strobe_own` is 1 during the pause, the initialization and every refresh cycle, and 0 when the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_grant | input | 1 | Strobes granted to the sequencer; held while `rfsh_req` is high |
| rfsh_req | output | 1 | Refresh owed or in progress |
| ready | output | 1 | Power-up pause and initialization complete |
| strobe_own | output | 1 | Sequencer is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |

## Verification
The hardest state to reach from the ports is a saturated backlog followed by a clean burst that no new interval interrupts. To get there, the stimulus withholds the grant for ten intervals. It then raises the grant in the clock right after an interval ends, so the burst of `BACKLOG_MAX` cycles finishes before the next interval ends, and the number of RAS falls in the burst is counted. Separate phases hold the grant high while idle and answer each request at once, so both the no-effect case and the normal single-refresh timing are covered.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } rfs_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int INTERVAL_CYC = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] tmr;

  assign tick = run && (tmr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (run) begin
      if (tmr == LAST) tmr <= '0;
      else             tmr <= tmr + 1'b1;
    end
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [BW-1:0] TOP = BW'(BACKLOG_MAX);

  logic [BW-1:0] owed;

  assign nonzero = (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (owed != TOP) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= TOP);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> owed != '0);

endmodule

// File: rtl/rfs_strobe_fsm.sv
module rfs_strobe_fsm
  import rfs_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 7,
  parameter int PRECH_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic pending,
  output logic take,
  output logic ready,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int CW = $clog2(max4(PAUSE_CYC, CAS_LEAD_CYC, RAS_LOW_CYC, PRECH_CYC) + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] PAUSE_LD = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] LEAD_LD  = CW'(CAS_LEAD_CYC - 1);
  localparam logic [CW-1:0] RASL_LD  = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] PRE_LD   = CW'(PRECH_CYC - 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

  rfs_state_t     state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  init_cnt;
  logic           at_end;

  assign at_end = (cnt == '0);

  always_comb begin
    take = pending && grant && ready &&
           ((state == ST_IDLE) || (state == ST_PRE && at_end));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_PAUSE;
      cnt      <= PAUSE_LD;
      init_cnt <= '0;
      ready    <= 1'b0;
    end else begin
      case (state)
        ST_PAUSE: begin
          if (at_end) begin
            state <= ST_CAS;
            cnt   <= LEAD_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_IDLE: begin
          if (take) begin
            state <= ST_CAS;
            cnt   <= LEAD_LD;
          end
        end
        ST_CAS: begin
          if (at_end) begin
            state <= ST_RAS;
            cnt   <= RASL_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RAS: begin
          if (at_end) begin
            state <= ST_PRE;
            cnt   <= PRE_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (!at_end) begin
            cnt <= cnt - 1'b1;
          end else if (!ready) begin
            if (init_cnt == INIT_LAST) begin
              state <= ST_IDLE;
              ready <= 1'b1;
            end else begin
              init_cnt <= init_cnt + 1'b1;
              state    <= ST_CAS;
              cnt      <= LEAD_LD;
            end
          end else if (take) begin
            state <= ST_CAS;
            cnt   <= LEAD_LD;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign ras_n = (state != ST_RAS);
  assign cas_n = !((state == ST_CAS) || (state == ST_RAS));
  assign we_n  = 1'b1;
  assign own   = (state != ST_IDLE);

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n && cas_n));

  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R7
  grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $rose(own)) |-> $past(grant));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = 1600,
  parameter int BACKLOG_MAX  = 8,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 7,
  parameter int PRECH_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_grant,
  output logic rfsh_req,
  output logic ready,
  output logic strobe_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  logic tick;
  logic take;
  logic pending;

  rfs_interval_timer #(
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ready),
    .tick (tick)
  );

  rfs_backlog #(
    .BACKLOG_MAX(BACKLOG_MAX)
  ) u_backlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (tick),
    .dec    (take),
    .nonzero(pending)
  );

  rfs_strobe_fsm #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INIT_CYCLES (INIT_CYCLES),
    .CAS_LEAD_CYC(CAS_LEAD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRECH_CYC   (PRECH_CYC)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .grant  (rfsh_grant),
    .pending(pending),
    .take   (take),
    .ready  (ready),
    .own    (strobe_own),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n)
  );

  assign rfsh_req = ready && (pending || strobe_own);

  // R6
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !rfsh_req);

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_own) |-> (ras_n && cas_n));

endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int P_PAUSE = 300;
  localparam int P_INIT  = 8;
  localparam int P_INT   = 100;
  localparam int P_MAX   = 8;
  localparam int P_LEAD  = 1;
  localparam int P_RASL  = 7;
  localparam int P_PRE   = 4;
  localparam int P_CYC   = P_LEAD + P_RASL + P_PRE;
  localparam int READY_AT = P_PAUSE + P_INIT * P_CYC;
  localparam int BURST_AT = READY_AT + 10 * P_INT;
  localparam int HOLD_LO  = 2000;
  localparam int HOLD_HI  = 2600;
  localparam int END_CYC  = 3200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfsh_grant = 1'b0;
  logic rfsh_req, ready, strobe_own, ras_n, cas_n, we_n;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .INTERVAL_CYC(P_INT),
    .BACKLOG_MAX(P_MAX), .CAS_LEAD_CYC(P_LEAD), .RAS_LOW_CYC(P_RASL),
    .PRECH_CYC(P_PRE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rfsh_grant(rfsh_grant), .rfsh_req(rfsh_req),
    .ready(ready), .strobe_own(strobe_own), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // reference model: queue of expected {ras_n, cas_n}, one entry per clock
  logic [1:0] q[$];
  int  init_left;
  int  owed_m;
  int  ready_cyc;
  bit  ready_m;

  task automatic push_refresh();
    for (int i = 0; i < P_LEAD; i++) q.push_back(2'b10);
    for (int i = 0; i < P_RASL; i++) q.push_back(2'b00);
    for (int i = 0; i < P_PRE;  i++) q.push_back(2'b11);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < P_PAUSE; i++) q.push_back(2'b11);
      init_left = P_INIT;
      owed_m    = 0;
      ready_cyc = 0;
      ready_m   = 0;
      cyc       = 0;
    end else begin
      int tk;
      int dc;
      cyc = cyc + 1;
      tk = 0;
      dc = 0;
      if (ready_m) begin
        if (((ready_cyc + 1) % P_INT) == 0) tk = 1;
        ready_cyc = ready_cyc + 1;
      end
      if (q.size() > 0) void'(q.pop_front());
      if (q.size() == 0) begin
        if (init_left > 0) begin
          push_refresh();
          init_left = init_left - 1;
        end else if (!ready_m) begin
          ready_m = 1;
        end else if (owed_m > 0 && rfsh_grant) begin
          push_refresh();
          dc = 1;
        end
      end
      owed_m = owed_m - dc + tk;
      if (owed_m > P_MAX) owed_m = P_MAX;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  logic prev_ras = 1'b1;
  logic prev_cas = 1'b1;
  int   low_run = 0;
  int   high_run = 0;
  int   init_falls = 0;
  int   burst_falls = 0;
  bit   ready_seen = 0;
  bit   started = 0;

  always @(negedge clk) begin
    if (started && !done) begin
      if (!rst_n) begin
        // R1 reset state
        check(ras_n == 1'b1 && cas_n == 1'b1, "R1 strobes in reset", {ras_n, cas_n}, 3);
        check(ready == 1'b0 && rfsh_req == 1'b0, "R1 ready/req in reset", {ready, rfsh_req}, 0);
        check(strobe_own == 1'b1, "R1 own in reset", strobe_own, 1);
      end else begin
        logic [1:0] e;
        bit own_e;
        bit req_e;
        own_e = (q.size() > 0);
        e = own_e ? q[0] : 2'b11;
        req_e = ready_m && (owed_m > 0 || own_e);
        // R1 R2 R4 R7 R9 cycle-by-cycle strobe compare
        check(ras_n == e[1], "R4 ras_n", ras_n, e[1]);
        check(cas_n == e[0], "R4 cas_n", cas_n, e[0]);
        // R4 write strobe
        check(we_n == 1'b1, "R4 we_n", we_n, 1);
        // R10
        check(strobe_own == own_e, "R10 strobe_own", strobe_own, own_e);
        // R3 R5
        check(ready == ready_m, "R3 ready", ready, ready_m);
        // R6
        check(rfsh_req == req_e, "R6 rfsh_req", rfsh_req, req_e);

        // R4 CAS-before-RAS order and strobe widths
        if (prev_ras && !ras_n) begin
          check(prev_cas == 1'b0, "R4 cas before ras", prev_cas, 0);
          if (!ready) init_falls++;
          if (cyc > BURST_AT && cyc < BURST_AT + P_MAX * P_CYC + 4) burst_falls++;
        end
        if (!ras_n) low_run++;
        if (!prev_ras && ras_n) begin
          check(low_run == P_RASL, "R4 ras low width", low_run, P_RASL);
          low_run = 0;
        end
        if (prev_cas && !cas_n) begin
          check(high_run >= P_PRE, "R4 precharge", high_run, P_PRE);
        end
        if (ras_n && cas_n) high_run++;
        else high_run = 0;

        // R2 init count and ready timing
        if (ready && !ready_seen) begin
          ready_seen = 1;
          check(cyc == READY_AT, "R2 ready cycle", cyc, READY_AT);
          check(init_falls == P_INIT, "R2 init cycles", init_falls, P_INIT);
        end
        // R8 saturated burst
        if (cyc == BURST_AT + P_MAX * P_CYC + 4) begin
          check(burst_falls == P_MAX, "R8 burst length", burst_falls, P_MAX);
        end
      end
      prev_ras = ras_n;
      prev_cas = cas_n;

      // grant stimulus
      if (cyc < BURST_AT)                        rfsh_grant = 1'b0;   // R8 withhold, R2 ignored
      else if (cyc >= HOLD_LO && cyc < HOLD_HI)  rfsh_grant = 1'b1;   // R9 grant while idle
      else                                       rfsh_grant = rfsh_req; // R7 prompt host
    end
  end

  initial begin
    rfsh_grant = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    started = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait (cyc >= END_CYC);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, END_CYC);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule